// File: doc/BRIEF.md
# Regulator Soft-Start and Fault Supervisor

This block is the digital start-up sequencer and output-fault guard of a step-down switching regulator. It decides when switching may run. It limits inductor current while the output charges. It watches a digitized feedback code against a reference code for output overvoltage and undervoltage, and turns a qualified fault into a latched command to the gate drivers. The sensing comparators, the ADC and the drivers themselves sit outside the block.

Switching may run only while the supply is valid and the enable input is high. The supply state uses hysteresis: an upper comparator flag sets it and a lower flag clears it. When switching starts, the block ramps the permitted current limit in four equal quarters. The ramp advances by counting high-side turn-on pulses, not by elapsed time. Undervoltage checking stays blanked for a set pulse count so that a rising output is not taken as a fault.

An overvoltage that persists latches the low-side switch on, which discharges the output. An undervoltage that persists latches both gates low. Each latch holds until enable is cycled or the supply state drops and rises again.

Top module: `softstart_fault_sup`

## Requirements
- R1: A run state is set when `vddAboveOn` is high, is kept while `vddAboveOff` stays high, and is cleared when `vddAboveOff` goes low. The block is active when the run state is set and `enIn` is high. Whenever it is not active, `forceBothLow` is 1 and `forceLowOn` is 0.
- R2: `ilimQuarter` encodes the allowed current limit in quarters of full scale: 1 means 25%, 2 means 50%, 3 means 75% and 4 means 100%. It reads 0 when not active. After activation it reads min(N / STEP_PULSES, 3) + 1, where N is the number of `hsPulse` cycles counted since activation.
- R3: `softStartDone` is 1 once 4·STEP_PULSES pulses have been counted while active, and 0 before that or when not active.
- R4: The undervoltage condition has no effect until BLANK_PULSES pulses have been counted since activation.
- R5: The overvoltage condition is 4·fbCode > 5·refCode. If it holds on OV_DELAY consecutive clock edges while active, `forceLowOn` latches to 1. Equality does not qualify.
- R6: The undervoltage condition is 10·fbCode < 7·refCode. If it holds on UV_DELAY consecutive clock edges after blanking has ended, `forceBothLow` latches to 1. Equality does not qualify.
- R7: A single edge without the condition restarts the delay count of that fault from zero.
- R8: A latched fault stays latched after its condition clears. It is released only when the block leaves the active state, either because enable went low or because the run state was cleared.
- R9: Only one fault can be latched at a time. Once either fault is latched, the other fault is ignored. If both qualify on the same edge, overvoltage wins.
- R10: During reset and immediately after it, the outputs are `forceBothLow`=1, `forceLowOn`=0, `ilimQuarter`=0 and `softStartDone`=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rstN | input | 1 | Asynchronous active-low reset (power-on) |
| vddAboveOn | input | 1 | Supply above the upper (turn-on) threshold |
| vddAboveOff | input | 1 | Supply above the lower (turn-off) threshold |
| enIn | input | 1 | Synchronized enable |
| hsPulse | input | 1 | One cycle per high-side turn-on |
| fbCode | input | FB_W | Digitized feedback voltage |
| refCode | input | FB_W | Reference code |
| ilimQuarter | output | 3 | Allowed current limit in quarters, 0 when idle |
| forceBothLow | output | 1 | Hold both gate drivers low |
| forceLowOn | output | 1 | Hold the low-side gate on |
| softStartDone | output | 1 | Current ramp finished |

## Verification
The run state, the pulse counter and both fault latches are single registers. A change in supply flags, enable or `hsPulse` therefore shows on the outputs after the next rising edge. The bench drives every input on a falling edge and checks on the following falling edge.

A fault condition applied at a falling edge latches on the DELAY-th rising edge that follows. The bench checks each filter one edge short of its delay, expecting no trip, and then on the delay edge itself, expecting the trip. Undervoltage arming depends on the pulse count. Its window therefore opens on the edge after the BLANK-th pulse is counted, and the delay edges are counted from there.

// File: rtl/sfs_pkg.sv
package sfs_pkg;

  // control -> datapath strobes
  typedef struct packed {
    logic runClear;
    logic countPulse;
    logic ovWatch;
    logic uvWatch;
  } sfsStrobe_t;

  // datapath -> control status
  typedef struct packed {
    logic       ovTrip;
    logic       uvTrip;
    logic       uvArmed;
    logic       rampDone;
    logic [1:0] stepIdx;
  } sfsStatus_t;

endpackage

// File: rtl/sfs_persist.sv
module sfs_persist #(
  parameter int DLY = 4
) (
  input  logic clk,
  input  logic rstN,
  input  logic clear,
  input  logic watch,
  input  logic cond,
  output logic trip
);
  localparam int CW = (DLY < 2) ? 1 : $clog2(DLY);
  localparam logic [CW-1:0] LAST = CW'(DLY - 1);

  logic [CW-1:0] runLen;

  assign trip = watch && cond && (runLen == LAST);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                      runLen <= '0;
    else if (clear || !watch || !cond) runLen <= '0;
    else if (runLen != LAST)         runLen <= runLen + 1'b1;
  end

  AST_PERSIST_BOUND: assert property (@(posedge clk) disable iff (!rstN)
    runLen <= LAST); // R7
  AST_PERSIST_RESTART: assert property (@(posedge clk) disable iff (!rstN)
    (!cond && !clear) |=> (runLen == '0)); // R7

endmodule

// File: rtl/sfs_datapath.sv
module sfs_datapath
  import sfs_pkg::*;
#(
  parameter int FB_W        = 10,
  parameter int STEP_PULSES = 128,
  parameter int BLANK_PULSES = 512,
  parameter int OV_DELAY    = 2000,
  parameter int UV_DELAY    = 250
) (
  input  logic            clk,
  input  logic            rstN,
  input  sfsStrobe_t      strobe,
  input  logic [FB_W-1:0] fbCode,
  input  logic [FB_W-1:0] refCode,
  output sfsStatus_t      status
);
  localparam int RAMP_TOTAL = 4 * STEP_PULSES;
  localparam int TOTAL = (RAMP_TOTAL > BLANK_PULSES) ? RAMP_TOTAL : BLANK_PULSES;
  localparam int CW = $clog2(TOTAL + 1);
  localparam int PW = FB_W + 4;
  localparam logic [CW-1:0] CNT_MAX = CW'(TOTAL);
  localparam logic [CW-1:0] STEP1   = CW'(STEP_PULSES);
  localparam logic [CW-1:0] STEP2   = CW'(2 * STEP_PULSES);
  localparam logic [CW-1:0] STEP3   = CW'(3 * STEP_PULSES);
  localparam logic [CW-1:0] STEP4   = CW'(RAMP_TOTAL);
  localparam logic [CW-1:0] ARM_AT  = CW'(BLANK_PULSES);

  logic [CW-1:0] pulseCnt;
  logic [PW-1:0] fbWide, refWide;
  logic          ovRaw, uvRaw;
  logic          ovTrip, uvTrip;
  logic [1:0]    stepIdx;

  // pulse counter shared by ramp and blanking
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                                        pulseCnt <= '0;
    else if (strobe.runClear)                         pulseCnt <= '0;
    else if (strobe.countPulse && pulseCnt != CNT_MAX) pulseCnt <= pulseCnt + 1'b1;
  end

  always_comb begin
    if (pulseCnt >= STEP3)      stepIdx = 2'd3;
    else if (pulseCnt >= STEP2) stepIdx = 2'd2;
    else if (pulseCnt >= STEP1) stepIdx = 2'd1;
    else                        stepIdx = 2'd0;
  end

  // threshold comparisons in integer form
  assign fbWide  = PW'(fbCode);
  assign refWide = PW'(refCode);
  assign ovRaw = (fbWide * PW'(4))  > (refWide * PW'(5));
  assign uvRaw = (fbWide * PW'(10)) < (refWide * PW'(7));

  sfs_persist #(.DLY(OV_DELAY)) uOvFilt (
    .clk(clk), .rstN(rstN), .clear(strobe.runClear),
    .watch(strobe.ovWatch), .cond(ovRaw), .trip(ovTrip));

  sfs_persist #(.DLY(UV_DELAY)) uUvFilt (
    .clk(clk), .rstN(rstN), .clear(strobe.runClear),
    .watch(strobe.uvWatch), .cond(uvRaw), .trip(uvTrip));

  assign status.ovTrip   = ovTrip;
  assign status.uvTrip   = uvTrip;
  assign status.uvArmed  = (pulseCnt >= ARM_AT);
  assign status.rampDone = (pulseCnt >= STEP4);
  assign status.stepIdx  = stepIdx;

  AST_CNT_BOUND: assert property (@(posedge clk) disable iff (!rstN)
    pulseCnt <= CNT_MAX); // R2
  AST_STEP_MONO: assert property (@(posedge clk) disable iff (!rstN)
    !strobe.runClear |=> (stepIdx >= $past(stepIdx))); // R2
  AST_BLANK_GUARD: assert property (@(posedge clk) disable iff (!rstN)
    uvTrip |-> (pulseCnt >= ARM_AT)); // R4
  AST_CLEAR_ZERO: assert property (@(posedge clk) disable iff (!rstN)
    strobe.runClear |=> (pulseCnt == '0)); // R2

endmodule

// File: rtl/sfs_ctrl.sv
module sfs_ctrl
  import sfs_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       vddAboveOn,
  input  logic       vddAboveOff,
  input  logic       enIn,
  input  logic       hsPulse,
  input  sfsStatus_t status,
  output sfsStrobe_t strobe,
  output logic [2:0] ilimQuarter,
  output logic       forceBothLow,
  output logic       forceLowOn,
  output logic       softStartDone
);
  logic supplyOk;
  logic active;
  logic ovLatch, uvLatch;
  logic anyFault;

  // supply hysteresis
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)            supplyOk <= 1'b0;
    else if (vddAboveOn)  supplyOk <= 1'b1;
    else if (!vddAboveOff) supplyOk <= 1'b0;
  end

  assign active   = supplyOk && enIn;
  assign anyFault = ovLatch || uvLatch;

  assign strobe.runClear   = !active;
  assign strobe.countPulse = active && hsPulse && !anyFault;
  assign strobe.ovWatch    = active && !anyFault;
  assign strobe.uvWatch    = active && !anyFault && status.uvArmed;

  // fault latches, overvoltage first
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      ovLatch <= 1'b0;
      uvLatch <= 1'b0;
    end else if (!active) begin
      ovLatch <= 1'b0;
      uvLatch <= 1'b0;
    end else if (!anyFault) begin
      if (status.ovTrip)      ovLatch <= 1'b1;
      else if (status.uvTrip) uvLatch <= 1'b1;
    end
  end

  assign forceBothLow  = !active || uvLatch;
  assign forceLowOn    = active && ovLatch;
  assign ilimQuarter   = active ? ({1'b0, status.stepIdx} + 3'd1) : 3'd0;
  assign softStartDone = active && status.rampDone;

  AST_FAULT_ONEHOT: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({ovLatch, uvLatch})); // R9
  AST_OV_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    (active && $past(active) && $past(ovLatch)) |-> ovLatch); // R8
  AST_UV_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    (active && $past(active) && $past(uvLatch)) |-> uvLatch); // R8
  AST_IDLE_CLEARS: assert property (@(posedge clk) disable iff (!rstN)
    !active |=> (!ovLatch && !uvLatch)); // R8
  AST_GATES_DISJOINT: assert property (@(posedge clk) disable iff (!rstN)
    !(forceBothLow && forceLowOn)); // R1

endmodule

// File: rtl/softstart_fault_sup.sv
module softstart_fault_sup
  import sfs_pkg::*;
#(
  parameter int FB_W         = 10,
  parameter int STEP_PULSES  = 128,
  parameter int BLANK_PULSES = 512,
  parameter int OV_DELAY     = 2000,
  parameter int UV_DELAY     = 250
) (
  input  logic            clk,
  input  logic            rstN,
  input  logic            vddAboveOn,
  input  logic            vddAboveOff,
  input  logic            enIn,
  input  logic            hsPulse,
  input  logic [FB_W-1:0] fbCode,
  input  logic [FB_W-1:0] refCode,
  output logic [2:0]      ilimQuarter,
  output logic            forceBothLow,
  output logic            forceLowOn,
  output logic            softStartDone
);
  sfsStrobe_t strobe;
  sfsStatus_t status;

  sfs_ctrl uCtrl (
    .clk(clk), .rstN(rstN),
    .vddAboveOn(vddAboveOn), .vddAboveOff(vddAboveOff),
    .enIn(enIn), .hsPulse(hsPulse),
    .status(status), .strobe(strobe),
    .ilimQuarter(ilimQuarter), .forceBothLow(forceBothLow),
    .forceLowOn(forceLowOn), .softStartDone(softStartDone));

  sfs_datapath #(
    .FB_W(FB_W), .STEP_PULSES(STEP_PULSES), .BLANK_PULSES(BLANK_PULSES),
    .OV_DELAY(OV_DELAY), .UV_DELAY(UV_DELAY)
  ) uDp (
    .clk(clk), .rstN(rstN), .strobe(strobe),
    .fbCode(fbCode), .refCode(refCode), .status(status));

endmodule

// File: tb/sim_softstart_fault_sup.sv
`timescale 1ns/1ps
module sim_softstart_fault_sup;
  localparam int FB_W = 8;
  localparam int STEP = 4;
  localparam int BLANK = 12;
  localparam int OVD = 6;
  localparam int UVD = 3;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic vddAboveOn = 1'b0, vddAboveOff = 1'b0, enIn = 1'b0, hsPulse = 1'b0;
  logic [FB_W-1:0] fbCode = '0, refCode = '0;
  logic [2:0] ilimQuarter;
  logic forceBothLow, forceLowOn, softStartDone;

  int total = 0;
  int bad = 0;
  bit finished = 1'b0;

  always #5 clk = ~clk;

  softstart_fault_sup #(
    .FB_W(FB_W), .STEP_PULSES(STEP), .BLANK_PULSES(BLANK),
    .OV_DELAY(OVD), .UV_DELAY(UVD)
  ) u0 (
    .clk(clk), .rstN(rstN), .vddAboveOn(vddAboveOn), .vddAboveOff(vddAboveOff),
    .enIn(enIn), .hsPulse(hsPulse), .fbCode(fbCode), .refCode(refCode),
    .ilimQuarter(ilimQuarter), .forceBothLow(forceBothLow),
    .forceLowOn(forceLowOn), .softStartDone(softStartDone));

  task automatic check(input string req, input int act, input int exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic pulse(input int n);
    for (int i = 0; i < n; i++) begin
      hsPulse = 1'b1;
      @(negedge clk);
      hsPulse = 1'b0;
    end
  endtask

  task automatic reenable();
    enIn = 1'b0;
    tick(1);
    fbCode = 8'd100;
    enIn = 1'b1;
    tick(1);
  endtask

  initial begin
    refCode = 8'd100;
    fbCode  = 8'd100;
    tick(2);
    // R10 reset values
    check("R10 bothLow", forceBothLow, 1);
    check("R10 lowOn", forceLowOn, 0);
    check("R10 ilim", ilimQuarter, 0);
    check("R10 done", softStartDone, 0);
    rstN = 1'b1;
    tick(1);
    check("R10 bothLow after", forceBothLow, 1);

    // R1 hysteresis
    enIn = 1'b1;
    vddAboveOff = 1'b1;
    tick(2);
    check("R1 lower flag only", forceBothLow, 1);
    vddAboveOn = 1'b1;
    tick(1);
    check("R1 run set", forceBothLow, 0);
    check("R2 first quarter", ilimQuarter, 1);
    vddAboveOn = 1'b0;
    tick(3);
    check("R1 hysteresis hold", forceBothLow, 0);

    // R2 R3 ramp sweep
    for (int n = 1; n <= 20; n++) begin
      pulse(1);
      check("R2 ramp step", ilimQuarter, ((n / STEP) > 3 ? 3 : (n / STEP)) + 1);
      check("R3 ramp done", softStartDone, (n >= 4 * STEP) ? 1 : 0);
    end
    enIn = 1'b0;
    tick(1);
    check("R2 idle code", ilimQuarter, 0);
    check("R3 idle done", softStartDone, 0);
    check("R1 idle gates", forceBothLow, 1);
    check("R1 idle lowOn", forceLowOn, 0);
    enIn = 1'b1;
    tick(1);
    check("R2 restart", ilimQuarter, 1);

    // R4 blanking then R6 trip
    fbCode = 8'd50;
    pulse(BLANK - 1);
    tick(8);
    check("R4 blanked", forceBothLow, 0);
    pulse(1);
    tick(UVD - 1);
    check("R6 before delay", forceBothLow, 0);
    tick(1);
    check("R6 uv trip", forceBothLow, 1);
    check("R6 lowOn off", forceLowOn, 0);
    fbCode = 8'd100;
    tick(5);
    check("R8 uv hold", forceBothLow, 1);
    fbCode = 8'd200;
    tick(OVD + 4);
    check("R9 ov ignored", forceLowOn, 0);
    reenable();
    check("R8 release by enable", forceBothLow, 0);
    check("R8 release lowOn", forceLowOn, 0);

    // R6 boundary
    pulse(BLANK);
    fbCode = 8'd70;
    tick(10);
    check("R6 equality", forceBothLow, 0);
    fbCode = 8'd69;
    tick(UVD);
    check("R6 just below", forceBothLow, 1);

    // R7 uv restart
    reenable();
    pulse(BLANK);
    fbCode = 8'd69;
    tick(UVD - 1);
    fbCode = 8'd100;
    tick(1);
    fbCode = 8'd69;
    tick(UVD - 1);
    check("R7 uv restarted", forceBothLow, 0);
    tick(1);
    check("R7 uv full run", forceBothLow, 1);

    // R5 overvoltage during soft-start
    reenable();
    fbCode = 8'd125;
    tick(20);
    check("R5 equality", forceLowOn, 0);
    fbCode = 8'd126;
    tick(OVD - 1);
    fbCode = 8'd100;
    tick(1);
    fbCode = 8'd126;
    tick(OVD - 1);
    check("R7 ov restarted", forceLowOn, 0);
    tick(1);
    check("R5 ov trip", forceLowOn, 1);
    check("R5 bothLow off", forceBothLow, 0);
    fbCode = 8'd100;
    tick(4);
    check("R8 ov hold", forceLowOn, 1);

    // R9 ov latched then uv ignored, R8 supply release
    reenable();
    pulse(BLANK);
    fbCode = 8'd200;
    tick(OVD);
    check("R5 ov armed trip", forceLowOn, 1);
    fbCode = 8'd30;
    tick(10);
    check("R9 uv ignored", forceBothLow, 0);
    check("R9 ov kept", forceLowOn, 1);
    vddAboveOff = 1'b0;
    tick(1);
    check("R1 supply drop", forceBothLow, 1);
    check("R8 supply drop lowOn", forceLowOn, 0);
    fbCode = 8'd100;
    vddAboveOff = 1'b1;
    vddAboveOn = 1'b1;
    tick(1);
    check("R8 release by supply", forceLowOn, 0);
    check("R8 running again", forceBothLow, 0);
    check("R2 ramp restart", ilimQuarter, 1);

    finished = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    #2000000;
    if (!finished) begin
      total++;
      bad++;
      $display("FAIL watchdog actual=0 expected=1");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

endmodule